// File: doc/BRIEF.md
# Audio Sample Float Codec

This block converts audio samples between a 24-bit signed two's-complement form and a compact 16-bit floating word, in either direction. A mode input picks the direction for each transaction. The packed word carries a sign bit, a 4-bit exponent and an 11-bit mantissa.

The exponent does not follow the IEEE scheme. It counts how many redundant copies of the sign sit at the top of the sample, and the count stops at twelve. Packing drops those redundant bits and keeps the next eleven. Unpacking puts an implicit bit back, equal to the inverse of the sign, and then shifts the value back down. When the exponent field has saturated, no implicit bit is restored.

The conversion logic is combinational. A single output register with a valid/ready handshake sits behind it, so a result appears one cycle after the input is accepted and stays stable while the consumer stalls.

Top module: `sample_codec`

## Requirements
- R1: In pack mode the packed word goes out on out_data[15:0] with out_data[23:16] zero. Bit 15 of the word is input bit 23, bits 14:11 hold the exponent and bits 10:0 hold the mantissa.
- R2: The pack exponent e is the number of consecutive positions i, stepping from 23 down to 12, at which input bit i equals input bit i-1. It stops at the first position where they differ, so its largest value is 12.
- R3: When e is below 12, the pack mantissa is input bits (21-e) down to (11-e).
- R4: When e is 12, the packed word is {sign, 4'b1111, in[10:0]} for a negative input and {sign, 4'b1100, in[10:0]} for a non-negative input.
- R5: In unpack mode, for an exponent field e from 0 to 11, the block forms the 24-bit value {s, ~s, m, 11'b0} from sign s (word bit 15) and mantissa m (word bits 10:0). It then shifts that value arithmetically right by e and drives the result on out_data.
- R6: In unpack mode, an exponent field of 12 to 15 forms {s, 1'b0, m, 11'b0} and shifts it arithmetically right by 11.
- R7: In unpack mode only in_data[15:0] is used. in_data[23:16] has no effect on the result.
- R8: mode 0 selects pack and mode 1 selects unpack. An input is accepted on a rising edge where in_valid and in_ready are both high, and its result shows on out_data with out_valid high after that edge.
- R9: While out_valid is high and out_ready is low, out_valid and out_data hold their values and in_ready is low.
- R10: After synchronous reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = pack, 1 = unpack |
| in_valid | input | 1 | Input transaction valid |
| in_ready | output | 1 | Block can accept an input |
| in_data | input | 24 | Sample (pack) or word in bits 15:0 (unpack) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 24 | Packed word zero-extended (pack) or sample (unpack) |

## Verification
The bench drives inputs at every exponent from 0 to 12, plus zero, all ones, the largest positive and the most negative sample. A wrong cap on the sign-bit count, or a mantissa window off by one, shows up there as a wrong exponent or shifted mantissa bits. Saturated words of both signs are unpacked as well. A design that inserts the implicit bit when the field is 12 or more, or that fails to clamp the shift at 11, gives wrong magnitudes on those words. Random words with junk in the upper input bits, and a stalled consumer, catch a design that leaks in_data[23:16] into unpack results or lets a held result change.

// File: rtl/sample_codec_pkg.sv
package sample_codec_pkg;
    localparam int SAMPLE_W = 24;
    localparam int EXP_W    = 4;
    localparam int MANT_W   = 11;
    localparam int WORD_W   = 1 + EXP_W + MANT_W;
    localparam int EXP_CAP  = SAMPLE_W - MANT_W - 1;
    localparam int MAX_SHR  = EXP_CAP - 1;

    typedef enum logic {
        MODE_PACK   = 1'b0,
        MODE_UNPACK = 1'b1
    } codec_mode_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } fword_t;
endpackage

// File: rtl/fp_pack.sv
module fp_pack
    import sample_codec_pkg::*;
(
    input  sample_t smp,
    output fword_t  word
);
    sample_t          diff;
    sample_t          shifted;
    logic [EXP_W-1:0] expo;
    logic             found;

    always_comb begin
        diff  = smp ^ {smp[SAMPLE_W-2:0], 1'b0};
        expo  = EXP_W'(EXP_CAP);
        found = 1'b0;
        for (int i = 0; i < EXP_CAP; i++) begin
            if (!found && diff[SAMPLE_W-1-i]) begin
                expo  = EXP_W'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        shifted   = smp << expo;
        word.sign = smp[SAMPLE_W-1];
        if (found) begin
            word.expo = expo;
            word.mant = shifted[SAMPLE_W-3 -: MANT_W];
        end else begin
            word.expo = smp[SAMPLE_W-1] ? {EXP_W{1'b1}} : EXP_W'(EXP_CAP);
            word.mant = smp[MANT_W-1:0];
        end
    end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
    import sample_codec_pkg::*;
(
    input  fword_t  word,
    output sample_t smp
);
    logic             saturated;
    logic [EXP_W-1:0] shamt;
    sample_t          staged;

    always_comb begin
        saturated = (word.expo > EXP_W'(MAX_SHR));
        shamt     = saturated ? EXP_W'(MAX_SHR) : word.expo;
        staged    = {word.sign, (~word.sign & ~saturated), word.mant, {(SAMPLE_W-2-MANT_W){1'b0}}};
        smp       = sample_t'($signed(staged) >>> shamt);
    end
endmodule

// File: rtl/codec_stage.sv
module codec_stage #(
    parameter int W       = 24,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    generate
        if (OUT_REG) begin : g_reg
            logic         vld_q;
            logic [W-1:0] dat_q;

            assign in_ready  = !vld_q || out_ready;
            assign out_valid = vld_q;
            assign out_data  = dat_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else if (in_ready) begin
                    vld_q <= in_valid;
                    if (in_valid) dat_q <= in_data;
                end
            end

            // R9
            stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
            // R9
            stall_block_chk: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !out_ready) |-> !in_ready);
            // R8
            accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready) |=> out_valid);
        end else begin : g_comb
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end
    endgenerate
endmodule

// File: rtl/sample_codec.sv
module sample_codec
    import sample_codec_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data
);
    localparam int PAD_W = SAMPLE_W - WORD_W;

    codec_mode_e sel;
    fword_t      packed_w;
    fword_t      unpack_in;
    sample_t     unpacked_s;
    sample_t     result;

    assign sel       = codec_mode_e'(mode);
    assign unpack_in = fword_t'(in_data[WORD_W-1:0]);

    fp_pack u_pack (
        .smp  (in_data),
        .word (packed_w)
    );

    fp_unpack u_unpack (
        .word (unpack_in),
        .smp  (unpacked_s)
    );

    always_comb begin
        if (sel == MODE_UNPACK) result = unpacked_s;
        else                    result = {{PAD_W{1'b0}}, packed_w};
    end

    codec_stage #(.W(SAMPLE_W), .OUT_REG(OUT_REG)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (result),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    generate
        if (OUT_REG) begin : g_chk
            // R1
            pack_sign_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready && mode == 1'b0) |=> (out_data[WORD_W-1] == $past(in_data[SAMPLE_W-1])));
            // R1
            pack_pad_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready && mode == 1'b0) |=> (out_data[SAMPLE_W-1:WORD_W] == '0));
            // R4
            pack_exp_range_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready && mode == 1'b0) |=>
                (out_data[WORD_W-2 -: EXP_W] != 4'd13 && out_data[WORD_W-2 -: EXP_W] != 4'd14));
            // R5
            unpack_sign_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && in_ready && mode == 1'b1) |=> (out_data[SAMPLE_W-1] == $past(in_data[WORD_W-1])));
        end
    endgenerate
endmodule

// File: tb/sample_codec_tb_top.sv
module sample_codec_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode;
    logic        in_valid;
    logic        in_ready;
    logic [23:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_data;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_codec dut_i (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    function automatic logic [23:0] ref_pack(input logic [23:0] x);
        int e = 0;
        logic [23:0] m;
        while (e < 12 && x[23-e] == x[22-e]) e++;
        if (e == 12)
            return {8'h00, x[23], (x[23] ? 4'hF : 4'hC), x[10:0]};
        m = (x << e) >> 11;
        return {8'h00, x[23], 4'(e), m[10:0]};
    endfunction

    function automatic logic [23:0] ref_unpack(input logic [15:0] w);
        int e = int'(w[14:11]);
        int mag = int'(w[10:0]) * 2048;
        int v;
        if (e > 11) begin
            e = 11;
            v = w[15] ? mag - 8388608 : mag;
        end else begin
            v = w[15] ? mag - 8388608 : mag + 4194304;
        end
        v = v >>> e;
        return v[23:0];
    endfunction

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic m, input logic [23:0] d, input logic [23:0] exp, input string req);
        @(negedge clk);
        mode = m; in_data = d; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({23'd0, out_valid}, 24'd1, "R8");
        check(out_data, exp, req);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; mode = 1'b0; in_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check({23'd0, out_valid}, 24'd0, "R10");
        check({23'd0, in_ready}, 24'd1, "R10");
    endtask

    task automatic t_pack_edges();
        run_one(1'b0, 24'h000000, 24'h006000, "R4");
        run_one(1'b0, 24'hFFFFFF, 24'h00FFFF, "R4");
        run_one(1'b0, 24'h7FFFFF, 24'h0007FF, "R3");
        run_one(1'b0, 24'h800000, 24'h008000, "R1");
        run_one(1'b0, 24'h000123, 24'h006123, "R4");
        run_one(1'b0, 24'hFFF9A5, 24'h00F9A5, "R4");
        for (int e = 0; e < 12; e++) begin
            logic [23:0] x = (24'h1 << (22 - e)) | 24'h000555;
            run_one(1'b0, x, ref_pack(x), "R2");
            run_one(1'b0, ~x, ref_pack(~x), "R3");
        end
    endtask

    task automatic t_unpack_edges();
        run_one(1'b1, 24'h000000, 24'h400000, "R5");
        run_one(1'b1, 24'h008000, 24'h800000, "R5");
        run_one(1'b1, 24'h0007FF, 24'h7FF800, "R5");
        run_one(1'b1, 24'h00FFFF, 24'hFFF7FF, "R6");
        run_one(1'b1, 24'h006000, 24'h000000, "R6");
        for (int e = 0; e < 16; e++) begin
            logic [15:0] w = {1'b0, 4'(e), 11'h2A5};
            run_one(1'b1, {8'h00, w}, ref_unpack(w), e > 11 ? "R6" : "R5");
            w[15] = 1'b1;
            run_one(1'b1, {8'h00, w}, ref_unpack(w), e > 11 ? "R6" : "R5");
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [23:0] x = 24'($urandom);
            run_one(1'b0, x, ref_pack(x), "R2");
            run_one(1'b1, x, ref_unpack(x[15:0]), "R7");
        end
    endtask

    task automatic t_stall();
        logic [23:0] a = 24'h012345;
        logic [23:0] b = 24'h00C3A1;
        @(negedge clk);
        out_ready = 1'b0; mode = 1'b0; in_data = a; in_valid = 1'b1;
        @(negedge clk);
        mode = 1'b1; in_data = b;
        check({23'd0, out_valid}, 24'd1, "R9");
        check(out_data, ref_pack(a), "R9");
        check({23'd0, in_ready}, 24'd0, "R9");
        repeat (2) @(negedge clk);
        check(out_data, ref_pack(a), "R9");
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({23'd0, out_valid}, 24'd1, "R8");
        check(out_data, ref_unpack(b[15:0]), "R9");
        @(negedge clk);
        check({23'd0, out_valid}, 24'd0, "R8");
    endtask

    initial begin
        t_reset();
        t_pack_edges();
        t_unpack_edges();
        t_random();
        t_stall();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule